// File: doc/BRIEF.md
# IP Class Priority Mapper

This block turns the IP class field of an arriving frame into one of four output queue numbers. It does this separately for each of three ingress ports. It holds two lookup tables. The IPv4 table has 64 entries and the IPv6 table has 256 entries. Every entry carries three 2-bit priorities, one per ingress port. Forwarding logic presents an ingress port number, a table choice and an 8-bit class index on the lookup port. The selected priority comes back one clock later.

Software reaches both tables through one 32-bit indirect configuration word.

- Every write latches a table choice and an entry address.
- A write normally also stores the three priority fields into that entry.
- A control bit in the word turns a write into a pointer move only. The tables are then left unchanged.
- The word read back always shows the live table contents at the latched pointer, not the data last written.

Top module: `ip_prio_map`

## Requirements
- R1: While `rst` is high and on the cycle after it, `cfg_rdata` and `lk_prio` are zero. After reset every entry of both tables holds priority 0 for all three ports, and the latched address and table choice are zero.
- R2: A write with bit 31 clear and bit 8 set stores the IPv4 entry. The entry address is taken from bits 5:0. Bits 10:9 go to the port 0 priority, bits 12:11 to port 1 and bits 14:13 to port 2. The IPv6 table is left unchanged.
- R3: A write with bit 31 clear and bit 8 clear stores the IPv6 entry addressed by bits 7:0 (0 to 255), with the same field positions. The IPv4 table is left unchanged.
- R4: A write with bit 31 set latches only the table choice and address. Neither table changes.
- R5: Two cycles after a write, `cfg_rdata` shows the following, and it keeps tracking table updates at that pointer:
  - bits 7:0: the latched address;
  - bit 8: the latched table choice;
  - bits 14:9: the three priorities currently stored at that entry;
  - bit 31: zero.
- R6: A lookup with port p in 0..2 returns, one cycle later on `lk_prio`, the 2-bit priority of port p in the addressed entry. The encoding 0, 1, 2, 3 means output queue 0, 1, 2, 3. `lk_sel` = 1 picks the IPv4 table and 0 picks IPv6.
- R7: A lookup with port number 3 returns priority 0.
- R8: For the IPv4 table, bits 7:6 of both the write address and the lookup index are ignored. The address read back in `cfg_rdata` bits 7:0 is the masked value.
- R9: A table write and a lookup of the same entry in the same cycle are both served, and the lookup returns the entry contents from before the write.
- R10: Bits 30:15 of a written word have no effect and always read back as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_wr | input | 1 | Configuration write strobe, one cycle per write |
| cfg_wdata | input | 32 | Configuration word written |
| cfg_rdata | output | 32 | Configuration word read back (pointer and live entry) |
| lk_port | input | 2 | Ingress port of the lookup (0 to 2; 3 gives priority 0) |
| lk_sel | input | 1 | Lookup table choice: 1 IPv4, 0 IPv6 |
| lk_idx | input | 8 | Class index of the lookup |
| lk_prio | output | 2 | Priority (output queue) returned one cycle after the lookup |

## Verification
The assertions check the following on every cycle:
- a write reaches the table that its select bit names and no other;
- a pointer-only write and an idle cycle leave both tables untouched;
- port 3 always yields queue 0;
- the reserved and control bits read back as zero;
- the latched select echoes back two cycles after a write;
- both outputs are cleared by reset.

Only the bench's scenarios can show that the right data landed in the right entry and that readback follows later writes at the latched pointer. The same holds for the read-before-write result on a same-cycle collision, the modulo-64 IPv4 addressing and the table contents being wiped by a second reset. The bench covers these by running a behavioural table model against the outputs on every clock.

// File: rtl/prio_map_pkg.sv
package prio_map_pkg;

  // Width of the indirect configuration word
  localparam int unsigned CFG_W = 32;

  // Table choice carried in the select bit
  typedef enum logic {
    TBL_V6 = 1'b0,
    TBL_V4 = 1'b1
  } tbl_sel_e;

endpackage

// File: rtl/prio_cfg_port.sv
// Decodes the indirect configuration word: latches the pointer on every
// write and raises one table write enable unless the word is pointer-only.
module prio_cfg_port
  import prio_map_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned V4_AW  = 6,
  parameter int unsigned ENT_W  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr,
  input  logic [CFG_W-1:0]  cfg_wdata,
  output logic [ADDR_W-1:0] ptr_addr,
  output logic              ptr_sel,
  output logic              wr_v4,
  output logic              wr_v6,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [ENT_W-1:0]  wr_entry
);

  localparam int unsigned SEL_BIT  = ADDR_W;
  localparam int unsigned PRIO_LSB = ADDR_W + 1;
  localparam int unsigned RSV_LSB  = PRIO_LSB + ENT_W;
  localparam int unsigned CTL_BIT  = CFG_W - 1;

  tbl_sel_e    sel_in;
  logic        ptr_only;
  logic [ADDR_W-1:0] addr_in;
  logic        rsv_unused;

  assign sel_in   = tbl_sel_e'(cfg_wdata[SEL_BIT]);
  assign ptr_only = cfg_wdata[CTL_BIT];

  always_comb begin
    addr_in = cfg_wdata[ADDR_W-1:0];
    if (sel_in == TBL_V4) begin
      addr_in = '0;
      addr_in[V4_AW-1:0] = cfg_wdata[V4_AW-1:0];
    end
  end

  // Reserved field is accepted and dropped
  assign rsv_unused = ^cfg_wdata[CTL_BIT-1:RSV_LSB];

  assign wr_v4    = cfg_wr && !ptr_only && (sel_in == TBL_V4);
  assign wr_v6    = cfg_wr && !ptr_only && (sel_in == TBL_V6);
  assign wr_addr  = addr_in;
  assign wr_entry = cfg_wdata[PRIO_LSB +: ENT_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_addr <= '0;
      ptr_sel  <= 1'b0;
    end else if (cfg_wr) begin
      ptr_addr <= addr_in;
      ptr_sel  <= cfg_wdata[SEL_BIT];
    end
  end

endmodule

// File: rtl/prio_table_ram.sv
// One write port, two synchronous read ports, read-before-write. Contents
// have no reset; a per-entry written flag, cleared by reset, masks stale data.
module prio_table_ram #(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned DW    = 6,
  parameter int unsigned AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] ra_addr,
  output logic [DW-1:0] ra_data,
  input  logic [AW-1:0] rb_addr,
  output logic [DW-1:0] rb_data
);

  logic [DW-1:0]    mem [DEPTH];
  logic [DEPTH-1:0] written;
  logic [DW-1:0]    ra_q, rb_q;
  logic             ra_ok, rb_ok;

  // Storage: no reset so it maps onto block RAM
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    ra_q <= mem[ra_addr];
    rb_q <= mem[rb_addr];
  end

  // Written flags in fabric registers
  always_ff @(posedge clk) begin
    if (rst) begin
      written <= '0;
      ra_ok   <= 1'b0;
      rb_ok   <= 1'b0;
    end else begin
      if (we) written[waddr] <= 1'b1;
      ra_ok <= written[ra_addr];
      rb_ok <= written[rb_addr];
    end
  end

  assign ra_data = ra_ok ? ra_q : '0;
  assign rb_data = rb_ok ? rb_q : '0;

endmodule

// File: rtl/prio_lane_pick.sv
// Selects one port's priority out of a table entry; out-of-range port gives 0.
module prio_lane_pick #(
  parameter int unsigned NUM_PORTS = 3,
  parameter int unsigned PRIO_W    = 2,
  parameter int unsigned PORT_W    = 2,
  parameter int unsigned ENT_W     = NUM_PORTS * PRIO_W
) (
  input  logic [ENT_W-1:0]  entry,
  input  logic [PORT_W-1:0] port,
  output logic [PRIO_W-1:0] prio
);

  always_comb begin
    prio = '0;
    for (int i = 0; i < NUM_PORTS; i++) begin
      if (int'(port) == i) prio = entry[i*PRIO_W +: PRIO_W];
    end
  end

endmodule

// File: rtl/ip_prio_map.sv
module ip_prio_map
  import prio_map_pkg::*;
#(
  parameter int unsigned NUM_PORTS = 3,
  parameter int unsigned PRIO_W    = 2,
  parameter int unsigned V4_DEPTH  = 64,
  parameter int unsigned V6_DEPTH  = 256,
  parameter int unsigned ADDR_W    = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  input  logic [1:0]        lk_port,
  input  logic              lk_sel,
  input  logic [7:0]        lk_idx,
  output logic [1:0]        lk_prio
);

  localparam int unsigned ENT_W   = NUM_PORTS * PRIO_W;
  localparam int unsigned V4_AW   = $clog2(V4_DEPTH);
  localparam int unsigned V6_AW   = $clog2(V6_DEPTH);
  localparam int unsigned PORT_W  = 2;
  localparam int unsigned RSV_W   = CFG_W - 2 - ENT_W - ADDR_W;

  logic [ADDR_W-1:0] ptr_addr, wr_addr;
  logic              ptr_sel;
  logic              v4_we, v6_we;
  logic [ENT_W-1:0]  wr_entry;

  logic [ENT_W-1:0]  v4_cfg_ent, v4_lk_ent, v6_cfg_ent, v6_lk_ent;
  logic [ADDR_W-1:0] ptr_addr_d;
  logic              ptr_sel_d;
  logic [PORT_W-1:0] lk_port_d;
  logic              lk_sel_d;
  logic [ENT_W-1:0]  cfg_ent, lk_ent;
  logic [PRIO_W-1:0] lk_pick;

  prio_cfg_port #(
    .ADDR_W (ADDR_W),
    .V4_AW  (V4_AW),
    .ENT_W  (ENT_W)
  ) u_cfg (
    .clk      (clk),
    .rst      (rst),
    .cfg_wr   (cfg_wr),
    .cfg_wdata(cfg_wdata),
    .ptr_addr (ptr_addr),
    .ptr_sel  (ptr_sel),
    .wr_v4    (v4_we),
    .wr_v6    (v6_we),
    .wr_addr  (wr_addr),
    .wr_entry (wr_entry)
  );

  prio_table_ram #(
    .DEPTH(V4_DEPTH),
    .DW   (ENT_W)
  ) u_v4_tbl (
    .clk    (clk),
    .rst    (rst),
    .we     (v4_we),
    .waddr  (wr_addr[V4_AW-1:0]),
    .wdata  (wr_entry),
    .ra_addr(ptr_addr[V4_AW-1:0]),
    .ra_data(v4_cfg_ent),
    .rb_addr(lk_idx[V4_AW-1:0]),
    .rb_data(v4_lk_ent)
  );

  prio_table_ram #(
    .DEPTH(V6_DEPTH),
    .DW   (ENT_W)
  ) u_v6_tbl (
    .clk    (clk),
    .rst    (rst),
    .we     (v6_we),
    .waddr  (wr_addr[V6_AW-1:0]),
    .wdata  (wr_entry),
    .ra_addr(ptr_addr[V6_AW-1:0]),
    .ra_data(v6_cfg_ent),
    .rb_addr(lk_idx[V6_AW-1:0]),
    .rb_data(v6_lk_ent)
  );

  // Align pointer and lookup controls with the one-cycle RAM read
  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_addr_d <= '0;
      ptr_sel_d  <= 1'b0;
      lk_port_d  <= '0;
      lk_sel_d   <= 1'b0;
    end else begin
      ptr_addr_d <= ptr_addr;
      ptr_sel_d  <= ptr_sel;
      lk_port_d  <= lk_port;
      lk_sel_d   <= lk_sel;
    end
  end

  assign cfg_ent = (tbl_sel_e'(ptr_sel_d) == TBL_V4) ? v4_cfg_ent : v6_cfg_ent;
  assign lk_ent  = (tbl_sel_e'(lk_sel_d)  == TBL_V4) ? v4_lk_ent  : v6_lk_ent;

  prio_lane_pick #(
    .NUM_PORTS(NUM_PORTS),
    .PRIO_W   (PRIO_W),
    .PORT_W   (PORT_W)
  ) u_pick (
    .entry(lk_ent),
    .port (lk_port_d),
    .prio (lk_pick)
  );

  assign lk_prio   = lk_pick;
  assign cfg_rdata = {1'b0, {RSV_W{1'b0}}, cfg_ent, ptr_sel_d, ptr_addr_d};

endmodule

// File: rtl/ip_prio_map_chk.sv
module ip_prio_map_chk #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned ENT_W  = 6
) (
  input logic        clk,
  input logic        rst,
  input logic        cfg_wr,
  input logic [31:0] cfg_wdata,
  input logic [31:0] cfg_rdata,
  input logic [1:0]  lk_port,
  input logic [1:0]  lk_prio,
  input logic        v4_we,
  input logic        v6_we
);

  localparam int unsigned SEL_BIT = ADDR_W;
  localparam int unsigned RSV_LSB = ADDR_W + 1 + ENT_W;

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (cfg_rdata == 32'd0 && lk_prio == 2'd0));

  assert_v4_only_R2: assert property (@(posedge clk) disable iff (rst)
    (cfg_wr && !cfg_wdata[31] && cfg_wdata[SEL_BIT]) |-> (v4_we && !v6_we));

  assert_v6_only_R3: assert property (@(posedge clk) disable iff (rst)
    (cfg_wr && !cfg_wdata[31] && !cfg_wdata[SEL_BIT]) |-> (v6_we && !v4_we));

  assert_ptr_only_R4: assert property (@(posedge clk) disable iff (rst)
    (cfg_wr && cfg_wdata[31]) |-> (!v4_we && !v6_we));

  assert_idle_no_write_R4: assert property (@(posedge clk) disable iff (rst)
    !cfg_wr |-> (!v4_we && !v6_we));

  assert_sel_echo_R5: assert property (@(posedge clk) disable iff (rst)
    cfg_wr |=> ##1 (cfg_rdata[SEL_BIT] == $past(cfg_wdata[SEL_BIT], 2)));

  assert_port3_zero_R7: assert property (@(posedge clk) disable iff (rst)
    (lk_port == 2'd3) |=> (lk_prio == 2'd0));

  assert_rsv_zero_R10: assert property (@(posedge clk) disable iff (rst)
    cfg_rdata[31:RSV_LSB] == '0);

endmodule

bind ip_prio_map ip_prio_map_chk #(
  .ADDR_W(ADDR_W),
  .ENT_W (ENT_W)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .cfg_wr   (cfg_wr),
  .cfg_wdata(cfg_wdata),
  .cfg_rdata(cfg_rdata),
  .lk_port  (lk_port),
  .lk_prio  (lk_prio),
  .v4_we    (v4_we),
  .v6_we    (v6_we)
);

// File: tb/test_ip_prio_map.sv
`timescale 1ns/1ps
module test_ip_prio_map;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_wr = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic [1:0]  lk_port = '0;
  logic        lk_sel = 1'b0;
  logic [7:0]  lk_idx = '0;
  logic [1:0]  lk_prio;

  int    n_run  = 0;
  int    n_fail = 0;
  bit    done   = 0;
  bit    started = 0;
  string cur_req = "R1";

  // Behavioural model state
  int          v4t [0:63][0:2];
  int          v6t [0:255][0:2];
  int          m_addr, m_sel;
  logic [31:0] exp_rd = '0;
  logic [1:0]  exp_lk = '0;

  always #5 clk = ~clk;

  ip_prio_map i_ip_prio_map (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .lk_port(lk_port), .lk_sel(lk_sel),
    .lk_idx(lk_idx), .lk_prio(lk_prio)
  );

  function automatic logic [31:0] mk(bit ctl, bit sel, int addr, int p0, int p1, int p2, int rsv);
    return {ctl, 16'(rsv), 2'(p2), 2'(p1), 2'(p0), sel, 8'(addr)};
  endfunction

  task automatic chk(string req, string what, int act, int expv);
    n_run++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h at %0t", req, what, act, expv, $time);
    end
  endtask

  // Reference model: results from pre-edge state, then apply the write
  always @(posedge clk) begin
    started = 1;
    if (rst) begin
      for (int i = 0; i < 64; i++) for (int p = 0; p < 3; p++) v4t[i][p] = 0;
      for (int i = 0; i < 256; i++) for (int p = 0; p < 3; p++) v6t[i][p] = 0;
      m_addr = 0; m_sel = 0; exp_rd = '0; exp_lk = '0;
    end else begin
      int e0, e1, e2, a, s;
      if (m_sel == 1) begin e0 = v4t[m_addr][0]; e1 = v4t[m_addr][1]; e2 = v4t[m_addr][2]; end
      else            begin e0 = v6t[m_addr][0]; e1 = v6t[m_addr][1]; e2 = v6t[m_addr][2]; end
      exp_rd = 32'((e2 << 13) | (e1 << 11) | (e0 << 9) | (m_sel << 8) | m_addr);
      if (lk_port == 2'd3) exp_lk = 2'd0;
      else if (lk_sel)     exp_lk = 2'(v4t[lk_idx % 64][lk_port]);
      else                 exp_lk = 2'(v6t[lk_idx][lk_port]);
      if (cfg_wr) begin
        s = int'(cfg_wdata[8]);
        a = s ? int'(cfg_wdata[5:0]) : int'(cfg_wdata[7:0]);
        m_sel = s; m_addr = a;
        if (!cfg_wdata[31]) begin
          for (int p = 0; p < 3; p++) begin
            if (s == 1) v4t[a][p] = int'(cfg_wdata[9 + 2*p +: 2]);
            else        v6t[a][p] = int'(cfg_wdata[9 + 2*p +: 2]);
          end
        end
      end
    end
  end

  // Every-clock comparison, away from the active edge
  always @(negedge clk) begin
    if (started && !done) begin
      chk(cur_req, "cfg_rdata", int'(cfg_rdata), int'(exp_rd));
      chk(cur_req, "lk_prio",   int'(lk_prio),   int'(exp_lk));
    end
  end

  task automatic step(bit wr, logic [31:0] wd, int lp, bit ls, int li);
    @(negedge clk);
    cfg_wr = wr; cfg_wdata = wd;
    lk_port = 2'(lp); lk_sel = ls; lk_idx = 8'(li);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, '0, 0, 0, 0);
  endtask

  initial begin
    // R1: reset state
    cur_req = "R1";
    repeat (3) @(negedge clk);
    chk("R1", "cfg_rdata reset", int'(cfg_rdata), 0);
    chk("R1", "lk_prio reset", int'(lk_prio), 0);
    rst = 1'b0;
    for (int i = 0; i < 8; i++) step(0, '0, i % 3, i[0], i * 37);

    // R2: IPv4 writes and readback
    cur_req = "R2";
    step(1, mk(0, 1, 5, 1, 2, 3, 0), 0, 0, 0);
    idle(2);
    chk("R2", "v4 readback", int'(cfg_rdata), int'(mk(0, 1, 5, 1, 2, 3, 0)));
    step(1, mk(0, 1, 63, 3, 0, 2, 0), 0, 0, 0);
    idle(2);

    // R6: lookup per port
    cur_req = "R6";
    step(0, '0, 2, 1, 5);
    idle(1);
    chk("R6", "v4 port2 lookup", int'(lk_prio), 3);
    step(0, '0, 1, 1, 5); step(0, '0, 0, 1, 63); step(0, '0, 2, 1, 63); idle(1);

    // R3: IPv6 writes, tables independent
    cur_req = "R3";
    step(1, mk(0, 0, 255, 2, 1, 0, 0), 0, 0, 0);
    step(1, mk(0, 0, 5, 3, 3, 3, 0), 0, 0, 0);
    idle(2);
    chk("R3", "v6 readback", int'(cfg_rdata), int'(mk(0, 0, 5, 3, 3, 3, 0)));
    step(0, '0, 0, 1, 5); idle(1);
    chk("R3", "v4 entry 5 untouched", int'(lk_prio), 1);
    step(0, '0, 0, 0, 255); idle(1);
    chk("R3", "v6 entry 255 port0", int'(lk_prio), 2);

    // R4: pointer-only write
    cur_req = "R4";
    step(1, mk(1, 1, 5, 0, 0, 0, 0), 0, 0, 0);
    idle(2);
    chk("R4", "table kept on ptr-only", int'(cfg_rdata), int'(mk(0, 1, 5, 1, 2, 3, 0)));
    step(1, mk(1, 0, 200, 3, 3, 3, 0), 2, 0, 200); idle(1);
    chk("R4", "v6 200 unchanged", int'(lk_prio), 0);
    idle(1);

    // R5: readback tracks a later write at the latched pointer
    cur_req = "R5";
    step(1, mk(1, 0, 17, 0, 0, 0, 0), 0, 0, 0);
    idle(1);
    step(1, mk(0, 0, 17, 2, 2, 1, 0), 0, 0, 0);
    idle(2);
    chk("R5", "live readback", int'(cfg_rdata), int'(mk(0, 0, 17, 2, 2, 1, 0)));

    // R8: IPv4 upper address bits ignored
    cur_req = "R8";
    step(1, mk(0, 1, 8'hC9, 2, 3, 1, 0), 0, 0, 0);
    idle(2);
    chk("R8", "masked v4 address", int'(cfg_rdata[7:0]), 9);
    step(0, '0, 1, 1, 8'h49); idle(1);
    chk("R8", "v4 index mod 64", int'(lk_prio), 3);

    // R7: port 3 gives priority 0
    cur_req = "R7";
    step(0, '0, 3, 1, 9); idle(1);
    chk("R7", "port 3 lookup", int'(lk_prio), 0);
    step(0, '0, 3, 0, 5); idle(1);

    // R9: collision returns old contents
    cur_req = "R9";
    step(1, mk(0, 0, 5, 0, 1, 2, 0), 0, 0, 5); idle(1);
    chk("R9", "old data on collision", int'(lk_prio), 3);
    step(0, '0, 0, 0, 5); idle(1);
    chk("R9", "new data after collision", int'(lk_prio), 0);

    // R10: reserved bits ignored, read as zero
    cur_req = "R10";
    step(1, mk(0, 1, 33, 1, 1, 2, 16'hBEEF), 0, 0, 0);
    idle(2);
    chk("R10", "reserved ignored", int'(cfg_rdata), int'(mk(0, 1, 33, 1, 1, 2, 0)));

    // R6: mixed random traffic
    cur_req = "R6";
    for (int i = 0; i < 600; i++) begin
      step(($urandom % 3) == 0,
           mk(($urandom % 4) == 0, $urandom % 2, $urandom % 256,
              $urandom % 4, $urandom % 4, $urandom % 4, ($urandom % 8 == 0) ? 16'h1 : 0),
           $urandom % 4, $urandom % 2, $urandom % 256);
    end

    // R1: reset in mid-run clears the tables
    cur_req = "R1";
    @(negedge clk); rst = 1'b1; cfg_wr = 0;
    idle(2);
    rst = 1'b0;
    for (int i = 0; i < 40; i++) step(0, '0, i % 3, i[1], i * 7);
    step(0, '0, 1, 1, 5); idle(1);
    chk("R1", "v4 entry cleared", int'(lk_prio), 0);
    idle(2);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #1ms;
    if (!done) begin
      done = 1;
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule